// File: doc/BRIEF.md
# Self-Checking Latin-Square Check-Bit Encoder

This block computes the check bits of a single-error-correcting orthogonal Latin squares code for a data word of k = m² bits (16 bits by default, m = 4). It produces 2m check bits. The data word is viewed as an m × m grid. The first m check bits are the parities of the grid rows. The last m check bits are the parities of the grid columns. Every data bit therefore feeds exactly two check bits, and two data bits never share more than one check. Because of this, the check bits have no common logic, and any fault on one internal node can reach only one check bit.

The check bits are registered. A two-rail parity checker then watches the registered check vector. Every data bit appears in exactly two checks, so the XOR of all check bits is zero whenever the encoder and the register are fault-free. The checker forms one rail from the row-check half and the other rail from the column-check half. Equal rails (00 or 11) mean the vector is consistent. Unequal rails (01 or 10) mean a corrupted check vector. A registered error flag follows the rails one cycle later. The block sits on the write path of a protected memory, in front of the array.

Top module: `ols_sc_enc`

## Requirements
- R1: For r = 0..m-1, chk_o[r] is the XOR of data bits r·m through r·m+m-1 (row parity of the grid).
- R2: For j = 0..m-1, chk_o[m+j] is the XOR of data bits j, j+m, j+2m, …, j+(m-1)m (column parity of the grid).
- R3: Flipping any single data bit flips exactly two check bits: one in chk_o[m-1:0] and one in chk_o[2m-1:m].
- R4: When the check vector is fault-free, rail_o[1] (XOR of chk_o[m-1:0]) equals rail_o[0] (XOR of chk_o[2m-1:m]), so rail_o reads 00 or 11.
- R5: chk_o is a register. It shows the check bits of the data present at the previous rising clock edge, and it is all zeros while reset is active.
- R6: If an odd number of the encoded check bits are inverted before the register, rail_o reads 01 or 10 in the cycle after the corrupted vector is captured.
- R7: err_o is 1 exactly one cycle after rail_o read 01 or 10, is 0 one cycle after rail_o read 00 or 11, and is 0 during reset.
- R8: If two encoded check bits are inverted, rail_o stays at 00 or 11. An even-weight corruption is outside the detection model.
- R9: The data width parameter must equal the square of m; any other combination stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | K (16) | Data word to encode |
| chk_o | output | 2M (8) | Registered check bits, row parities low, column parities high |
| rail_o | output | 2 | Two-rail checker output, [1] row half, [0] column half |
| err_o | output | 1 | Registered mismatch of the two rails |

## Verification
The hardest condition to create from the ports is a faulty check vector. On a correct encoder, no data word produces one. The bench therefore overrides the internal encoded check net, just ahead of the register, with the model's vector XOR a chosen mask. It does this for each single-bit mask, for a three-bit mask and for two-bit masks, and then releases the net. It follows the corrupted vector through the register, the rails and the error flag cycle by cycle, and confirms that the flag clears once the override is gone.

// File: rtl/ols_pkg.sv
package ols_pkg;
  // number of check rows added per level of correction capability
  localparam int unsigned CorrLevels = 1;

  function automatic int unsigned n_checks(input int unsigned m);
    return 2 * CorrLevels * m;
  endfunction
endpackage

// File: rtl/ols_row_enc.sv
module ols_row_enc #(
  parameter int unsigned M = 4,
  localparam int unsigned K = M * M
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [K-1:0] data_i,
  output logic [M-1:0] row_o
);
  for (genvar r = 0; r < M; r++) begin : g_row
    assign row_o[r] = ^data_i[r*M +: M];
  end

  // every data bit sits in exactly one row, so row parities fold to word parity
  p_row_fold_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^row_o) == (^data_i));
endmodule

// File: rtl/ols_col_enc.sv
module ols_col_enc #(
  parameter int unsigned M = 4,
  localparam int unsigned K = M * M
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [K-1:0] data_i,
  output logic [M-1:0] col_o
);
  for (genvar j = 0; j < M; j++) begin : g_col
    logic [M-1:0] taps;
    for (genvar i = 0; i < M; i++) begin : g_tap
      assign taps[i] = data_i[i*M + j];
    end
    assign col_o[j] = ^taps;
  end

  // each data bit sits in exactly one column
  p_col_fold_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^col_o) == (^data_i));
endmodule

// File: rtl/ols_rail_chk.sv
module ols_rail_chk #(
  parameter int unsigned N = 8,
  localparam int unsigned H = N / 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] chk_i,
  output logic [1:0]   rail_o
);
  // disjoint halves, no shared gate between the rails
  assign rail_o[1] = ^chk_i[H-1:0];
  assign rail_o[0] = ^chk_i[N-1:H];

  // rails disagree exactly when the whole vector has odd weight
  p_rail_odd_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rail_o[1] ^ rail_o[0]) == (^chk_i));
endmodule

// File: rtl/ols_sc_enc.sv
module ols_sc_enc #(
  parameter int unsigned M       = 4,
  parameter int unsigned K       = 16,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned NC     = ols_pkg::n_checks(M)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [K-1:0]  data_i,
  output logic [NC-1:0] chk_o,
  output logic [1:0]    rail_o,
  output logic          err_o
);
  if (K != M * M) begin : g_bad_width
    $error("ols_sc_enc: K must equal M*M (R9)");
  end

  logic [M-1:0]  row_chk;
  logic [M-1:0]  col_chk;
  logic [NC-1:0] enc_chk;
  logic          err_d;
  logic          live_q;

  ols_row_enc #(.M(M)) u_row (
    .clk_i (clk_i), .rst_ni (rst_ni), .data_i (data_i), .row_o (row_chk)
  );

  ols_col_enc #(.M(M)) u_col (
    .clk_i (clk_i), .rst_ni (rst_ni), .data_i (data_i), .col_o (col_chk)
  );

  assign enc_chk = {col_chk, row_chk};

  if (REG_OUT) begin : g_reg
    logic [NC-1:0] chk_d;
    logic [NC-1:0] chk_q;

    always_comb begin
      chk_d = enc_chk;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chk_q <= '0;
      else         chk_q <= chk_d;
    end

    assign chk_o = chk_q;

    p_chk_reg_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_q |-> (chk_o == $past(enc_chk)));
  end else begin : g_comb
    assign chk_o = enc_chk;
  end

  ols_rail_chk #(.N(NC)) u_chk (
    .clk_i (clk_i), .rst_ni (rst_ni), .chk_i (chk_o), .rail_o (rail_o)
  );

  always_comb begin
    err_d = rail_o[1] ^ rail_o[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      err_o  <= err_d;
      live_q <= 1'b1;
    end
  end

  p_err_flag_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (err_o == $past(rail_o[1] != rail_o[0])));
endmodule

// File: tb/ols_sc_enc_tb_top.sv
module ols_sc_enc_tb_top;
  localparam int M  = 4;
  localparam int K  = 16;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [K-1:0]  data = '0;
  logic [NC-1:0] chk;
  logic [1:0]    rail;
  logic          err;
  logic [NC-1:0] fval;
  int            n_chk = 0;
  int            n_err = 0;
  bit            done = 1'b0;

  always #10ns clk = ~clk;

  ols_sc_enc dut_i (
    .clk_i (clk), .rst_ni (rst_n), .data_i (data),
    .chk_o (chk), .rail_o (rail), .err_o (err)
  );

  function automatic logic [NC-1:0] model(input logic [K-1:0] d);
    logic [NC-1:0] c = '0;
    for (int r = 0; r < M; r++)
      for (int i = 0; i < M; i++) c[r] ^= d[r*M + i];
    for (int j = 0; j < M; j++)
      for (int i = 0; i < M; i++) c[M+j] ^= d[j + i*M];
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [K-1:0] d);
    @(negedge clk) data = d;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R5 reset chk", chk, 0);
    check("R7 reset err", err, 0);
    check("R4 reset rails", rail, 0);
  endtask

  task automatic t_patterns;
    logic [K-1:0] pats [6] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1234, 16'hFFFE, 16'h8001};
    foreach (pats[p]) begin
      apply(pats[p]);
      check("R1 row checks", chk[M-1:0], model(pats[p]) & 8'h0F);
      check("R2 col checks", chk[NC-1:M], model(pats[p]) >> M);
      check("R4 rails equal", rail[1] ^ rail[0], 0);
      @(negedge clk);
      check("R7 err low", err, 0);
    end
  endtask

  task automatic t_latency;
    apply(16'h0000);
    @(negedge clk) data = 16'h0001;
    check("R5 no change before edge", chk, 0);
    @(negedge clk);
    check("R5 after edge", chk, model(16'h0001));
  endtask

  task automatic t_walk;
    logic [NC-1:0] base;
    base = model(16'h0000);
    for (int b = 0; b < K; b++) begin
      logic [NC-1:0] diff;
      apply(16'(1) << b);
      diff = chk ^ base;
      check("R3 two bits flip", $countones(diff), 2);
      check("R3 one per half", {$countones(diff[M-1:0]), $countones(diff[NC-1:M])}, 64'h1_0000_0001);
      check("R1 walk", chk[M-1:0], 4'(1) << (b / M));
      check("R2 walk", chk[NC-1:M], 4'(1) << (b % M));
    end
  endtask

  task automatic inject(input logic [K-1:0] d, input logic [NC-1:0] mask,
                        input bit odd);
    apply(d);
    @(negedge clk);
    fval = model(d) ^ mask;
    force dut_i.enc_chk = fval;
    @(negedge clk);
    release dut_i.enc_chk;
    check(odd ? "R6 rails differ" : "R8 rails equal", rail[1] ^ rail[0], odd);
    check("R7 err latency", err, 0);
    @(negedge clk);
    check("R7 err set", err, odd);
    check("R4 rails after release", rail[1] ^ rail[0], 0);
    @(negedge clk);
    check("R7 err clears", err, 0);
  endtask

  task automatic t_faults;
    for (int b = 0; b < NC; b++) inject(16'h5A3C ^ 16'(b), 8'(1) << b, 1'b1);
    inject(16'hC001, 8'b0100_1001, 1'b1);
    inject(16'h0F0F, 8'b0000_0011, 1'b0);
    inject(16'h7777, 8'b0001_0001, 1'b0);
  endtask

  initial begin
    #5ns;
    t_reset();
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_patterns();
    t_latency();
    t_walk();
    t_faults();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule